// File: doc/BRIEF.md
# Four-Word Register Load Sequencer

This block is the control and address slice of a 16-bit multi-cycle processor that carries out one load-multiple instruction. When the decode stage presents a matching instruction, the sequencer reads the base register once and adds the sign-extended offset, doubled, to it. It then fetches four consecutive 16-bit words from memory at two-byte steps and writes them into registers R0, R1, R2 and R3 in that order. Each word waits on its own memory-ready handshake. After the fourth write the sequencer gives control back to instruction fetch.

The block contains the memory address register, the memory data register, the address adder with its stepping path, and the counter that selects the destination register. The register file, the memory and the fetch and decode logic are outside the block. The register file offers one combinational read port that the sequencer addresses and one write port that it drives. The memory is reached through an address, a read request and a ready/data return.

Top module: `mload_seq`

## Requirements
- R1: While the sequencer is idle (busy low), an instruction presented with `dec_valid` high is accepted when bits [15:12] are 1000 and bits [11:9] are 000. `busy` is high from the next cycle and stays high until the cycle in which `fetch_go` pulses.
- R2: The sequencer ignores an instruction whose opcode field or bits [11:9] differ from that pattern. It also ignores `dec_valid` while busy. Neither case raises `busy`, `mem_read` or `rf_we`, and neither changes an ongoing sequence.
- R3: The first read address is the value of the register named in bits [8:6] plus the sign-extended 6-bit offset in bits [5:0] shifted left by one, taken modulo 2^16. That register is read once, before any register write, so a base register inside R0..R3 still gives the correct addresses.
- R4: The words at the first address plus 0, 2, 4 and 6 (modulo 2^16) are written to register indices 0, 1, 2 and 3, in ascending order. Each write is a single cycle with `rf_we` high, `rf_wr_idx` set to the index and `rf_wr_data` equal to the word. There is exactly one write per word.
- R5: Each read holds `mem_read` high and `mem_addr` steady until `mem_ready` is sampled high. The word is taken from `mem_rdata` on that clock edge.
- R6: One cycle after the fourth write, `fetch_go` is high for exactly one cycle and `busy` is low. With a ready delay of d cycles per word, `busy` is high for 1 + 4*(d+2) cycles.
- R7: Synchronous active-high reset, applied at any time including mid-sequence, returns the sequencer to idle with `busy`, `mem_read`, `rf_we` and `fetch_go` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode stage presents an instruction this cycle |
| instr | input | 16 | Instruction word from decode |
| busy | output | 1 | Sequencer owns the datapath |
| rf_rd_idx | output | 3 | Register file read index (base register) |
| rf_rd_data | input | 16 | Register file read data, combinational |
| mem_addr | output | 16 | Memory byte address (address register) |
| mem_read | output | 1 | Memory read request |
| mem_ready | input | 1 | Memory has returned the word on mem_rdata |
| mem_rdata | input | 16 | Memory read data |
| rf_we | output | 1 | Register file write enable |
| rf_wr_idx | output | 3 | Register file write index |
| rf_wr_data | output | 16 | Register file write data (data register) |
| fetch_go | output | 1 | One-cycle pulse handing control back to fetch |

## Verification
The checker assumes the memory asserts `mem_ready` only while `mem_read` is high. It also assumes the register file answers a read index combinationally in the same cycle. The bench memory model raises ready only after a read request has been held for the programmed delay, and drops it as soon as the request goes away. The bench register file is a plain array indexed by `rf_rd_idx`. The stimulus covers a different ready delay for each instruction, a negative offset, address wrap-around, a base register inside the destination set, a decode pulse during a sequence, and a reset in mid-flight.

// File: rtl/mload_pkg.sv
package mload_pkg;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_BASE  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } ml_state_e;

  localparam logic [3:0] ML_OPCODE   = 4'b1000;
  localparam logic [2:0] ML_SUBFIELD = 3'b000;

endpackage

// File: rtl/mload_ctrl.sv
module mload_ctrl
  import mload_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int IDX_W   = 3,
  parameter int OFF_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dec_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic               mem_ready,
  input  logic               last_word,
  output logic [IDX_W-1:0]   base_idx,
  output logic [OFF_W-1:0]   offset,
  output logic               do_base,
  output logic               do_mdr,
  output logic               do_step,
  output logic               mem_read,
  output logic               rf_we,
  output logic               busy,
  output logic               fetch_go
);

  localparam int OPC_LSB = INSTR_W - 4;
  localparam int SUB_LSB = OPC_LSB - 3;

  ml_state_e state, nxt;
  logic      hit;

  assign hit = dec_valid
            && (instr[INSTR_W-1:OPC_LSB] == ML_OPCODE)
            && (instr[OPC_LSB-1:SUB_LSB] == ML_SUBFIELD);

  always_comb begin
    nxt = state;
    case (state)
      ST_FETCH: if (hit) nxt = ST_BASE;
      ST_BASE:  nxt = ST_READ;
      ST_READ:  if (mem_ready) nxt = ST_WRITE;
      ST_WRITE: nxt = last_word ? ST_FETCH : ST_READ;
      default:  nxt = ST_FETCH;
    endcase
  end

  assign do_base = (state == ST_BASE);
  assign do_mdr  = (state == ST_READ) && mem_ready;
  assign do_step = (state == ST_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_FETCH;
      mem_read <= 1'b0;
      rf_we    <= 1'b0;
      busy     <= 1'b0;
      fetch_go <= 1'b0;
      base_idx <= '0;
      offset   <= '0;
    end else begin
      state    <= nxt;
      mem_read <= (nxt == ST_READ);
      rf_we    <= (nxt == ST_WRITE);
      busy     <= (nxt != ST_FETCH);
      fetch_go <= (state == ST_WRITE) && last_word;
      if ((state == ST_FETCH) && hit) begin
        base_idx <= instr[SUB_LSB-1:OFF_W];
        offset   <= instr[OFF_W-1:0];
      end
    end
  end

endmodule

// File: rtl/mload_addr.sv
module mload_addr #(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 6,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              do_base,
  input  logic              do_step,
  input  logic              do_mdr,
  input  logic [DATA_W-1:0] base_val,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mar,
  output logic [DATA_W-1:0] mdr
);

  localparam int EXT_W = DATA_W - OFF_W - 1;

  logic [DATA_W-1:0] disp;

  // offset counts words; the doubled, sign-extended value is a byte displacement
  assign disp = {{EXT_W{offset[OFF_W-1]}}, offset, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      mar <= '0;
      mdr <= '0;
    end else begin
      if (do_base)      mar <= base_val + disp;
      else if (do_step) mar <= mar + DATA_W'(STEP);
      if (do_mdr)       mdr <= mem_rdata;
    end
  end

endmodule

// File: rtl/mload_dest.sv
module mload_dest #(
  parameter int NWORDS    = 4,
  parameter int IDX_W     = 3,
  parameter int FIRST_REG = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             adv,
  output logic [IDX_W-1:0] dest,
  output logic             last_word
);

  localparam int CNT_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (clear) cnt <= '0;
    else if (adv)   cnt <= cnt + 1'b1;
  end

  assign last_word = (cnt == CNT_W'(NWORDS - 1));
  assign dest      = IDX_W'(FIRST_REG) + IDX_W'(cnt);

endmodule

// File: rtl/mload_seq.sv
module mload_seq #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 6,
  parameter int NWORDS = 4,
  parameter int STEP   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dec_valid,
  input  logic [6+IDX_W+OFF_W:0] instr,
  output logic                   busy,
  output logic [IDX_W-1:0]       rf_rd_idx,
  input  logic [DATA_W-1:0]      rf_rd_data,
  output logic [DATA_W-1:0]      mem_addr,
  output logic                   mem_read,
  input  logic                   mem_ready,
  input  logic [DATA_W-1:0]      mem_rdata,
  output logic                   rf_we,
  output logic [IDX_W-1:0]       rf_wr_idx,
  output logic [DATA_W-1:0]      rf_wr_data,
  output logic                   fetch_go
);

  localparam int INSTR_W = 7 + IDX_W + OFF_W;

  logic [OFF_W-1:0] offset;
  logic             do_base, do_mdr, do_step, last_word;

  mload_ctrl #(
    .INSTR_W(INSTR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .instr(instr),
    .mem_ready(mem_ready), .last_word(last_word),
    .base_idx(rf_rd_idx), .offset(offset),
    .do_base(do_base), .do_mdr(do_mdr), .do_step(do_step),
    .mem_read(mem_read), .rf_we(rf_we), .busy(busy), .fetch_go(fetch_go)
  );

  mload_addr #(
    .DATA_W(DATA_W), .OFF_W(OFF_W), .STEP(STEP)
  ) u_addr (
    .clk(clk), .rst(rst), .do_base(do_base), .do_step(do_step),
    .do_mdr(do_mdr), .base_val(rf_rd_data), .offset(offset),
    .mem_rdata(mem_rdata), .mar(mem_addr), .mdr(rf_wr_data)
  );

  mload_dest #(
    .NWORDS(NWORDS), .IDX_W(IDX_W), .FIRST_REG(0)
  ) u_dest (
    .clk(clk), .rst(rst), .clear(do_base), .adv(do_step),
    .dest(rf_wr_idx), .last_word(last_word)
  );

endmodule

// File: rtl/mload_seq_chk.sv
module mload_seq_chk #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  parameter int NWORDS = 4,
  parameter int STEP   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              dec_valid,
  input logic              busy,
  input logic [DATA_W-1:0] mem_addr,
  input logic              mem_read,
  input logic              mem_ready,
  input logic              rf_we,
  input logic [IDX_W-1:0]  rf_wr_idx,
  input logic              fetch_go
);

  localparam int CW = $clog2(NWORDS) + 1;

  logic [CW-1:0] wr_seen;
  logic          last_wr;

  always_ff @(posedge clk) begin
    if (rst || !busy) wr_seen <= '0;
    else if (rf_we)   wr_seen <= wr_seen + 1'b1;
  end

  assign last_wr = (wr_seen == CW'(NWORDS - 1));

  // environment: memory answers only an open request
  a_env_ready_in_read: assert property (@(posedge clk) disable iff (rst)
    mem_ready |-> mem_read);

  // R1
  a_r1_start_after_decode: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(dec_valid));
  a_r1_activity_inside_busy: assert property (@(posedge clk) disable iff (rst)
    (mem_read || rf_we) |-> busy);

  // R3
  a_r3_address_step: assert property (@(posedge clk) disable iff (rst)
    (rf_we && !last_wr) |=> (mem_read && mem_addr == DATA_W'($past(mem_addr) + DATA_W'(STEP))));

  // R4
  a_r4_single_write: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we);
  a_r4_ascending_dest: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_wr_idx == IDX_W'(wr_seen)));

  // R5
  a_r5_request_held: assert property (@(posedge clk) disable iff (rst)
    (mem_read && !mem_ready) |=> (mem_read && $stable(mem_addr)));

  // R6
  a_r6_return_after_last: assert property (@(posedge clk) disable iff (rst)
    (rf_we && last_wr) |=> (fetch_go && !busy));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    fetch_go |=> !fetch_go);

  // R7
  a_r7_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !mem_read && !rf_we && !fetch_go));

endmodule

bind mload_seq mload_seq_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .NWORDS(NWORDS), .STEP(STEP)
) u_chk (
  .clk(clk), .rst(rst), .dec_valid(dec_valid), .busy(busy),
  .mem_addr(mem_addr), .mem_read(mem_read), .mem_ready(mem_ready),
  .rf_we(rf_we), .rf_wr_idx(rf_wr_idx), .fetch_go(fetch_go)
);

// File: tb/tb_mload_seq.sv
module tb_mload_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dec_valid = 1'b0;
  logic [15:0] instr = '0;
  logic        busy;
  logic [2:0]  rf_rd_idx;
  logic [15:0] rf_rd_data;
  logic [15:0] mem_addr;
  logic        mem_read;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        rf_we;
  logic [2:0]  rf_wr_idx;
  logic [15:0] rf_wr_data;
  logic        fetch_go;

  typedef struct {
    logic [2:0]  idx;
    logic [15:0] addr;
    logic [15:0] data;
  } exp_t;

  exp_t        exp_q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  int          mem_delay = 0;
  int          wcnt = 0;
  logic [15:0] rf [8];
  logic        pre_we = 1'b0;
  logic [2:0]  pre_idx = '0;
  logic [15:0] pre_val = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mload_seq dut (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .instr(instr), .busy(busy),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .mem_addr(mem_addr),
    .mem_read(mem_read), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .rf_we(rf_we), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .fetch_go(fetch_go)
  );

  function automatic logic [15:0] memval(input logic [15:0] a);
    return ({a[7:0], a[15:8]} ^ 16'hC35A) + 16'd17;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // register file model: one writer
  always @(posedge clk) begin
    if (pre_we)     rf[pre_idx] <= pre_val;
    else if (rf_we) rf[rf_wr_idx] <= rf_wr_data;
  end
  assign rf_rd_data = rf[rf_rd_idx];

  // memory model with programmable ready delay; checks request address (R3, R5)
  always @(negedge clk) begin
    if (rst || !mem_read) begin
      mem_ready <= 1'b0;
      wcnt      <= 0;
    end else if (!mem_ready) begin
      if (wcnt == mem_delay) begin
        mem_ready <= 1'b1;
        mem_rdata <= memval(mem_addr);
        if (exp_q.size() == 0)
          chk(1'b0, "R4", "read with no expected word", 32'(mem_addr), 0);
        else
          chk(mem_addr == exp_q[0].addr, "R3", "read address", 32'(mem_addr), 32'(exp_q[0].addr));
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  // scoreboard monitor for register writes (R4)
  always @(negedge clk) begin
    if (!rst && rf_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected write", 32'(rf_wr_idx), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rf_wr_idx == e.idx, "R4", "write index", 32'(rf_wr_idx), 32'(e.idx));
        chk(rf_wr_data == e.data, "R4", "write data", 32'(rf_wr_data), 32'(e.data));
      end
    end
  end

  task automatic preload(input logic [2:0] idx, input logic [15:0] val);
    pre_we = 1'b1; pre_idx = idx; pre_val = val;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic issue(input logic [2:0] breg, input logic [15:0] bval,
                       input logic [5:0] off, input int dly, input bit inject);
    logic [15:0] a0;
    int cyc;
    int guard;
    preload(breg, bval);
    mem_delay = dly;
    a0 = bval + {{9{off[5]}}, off, 1'b0};
    for (int k = 0; k < 4; k++) begin
      exp_t e;
      e.idx  = 3'(k);
      e.addr = a0 + 16'(2 * k);
      e.data = memval(e.addr);
      exp_q.push_back(e);
    end
    dec_valid = 1'b1;
    instr = {4'b1000, 3'b000, breg, off};
    @(negedge clk);
    dec_valid = 1'b0;
    instr = '0;
    chk(busy == 1'b1, "R1", "busy after decode", 32'(busy), 1);
    cyc = 0;
    guard = 0;
    while (!fetch_go && guard < 2000) begin
      if (busy) cyc++;
      guard++;
      if (inject && cyc == 3) begin
        dec_valid = 1'b1; instr = 16'h817F;   // R2: valid pattern while busy
      end else begin
        dec_valid = 1'b0; instr = '0;
      end
      @(negedge clk);
    end
    dec_valid = 1'b0;
    instr = '0;
    chk(fetch_go == 1'b1, "R6", "return pulse", 32'(fetch_go), 1);
    chk(busy == 1'b0, "R6", "busy at return", 32'(busy), 0);
    chk(cyc == 1 + 4 * (dly + 2), "R6", "busy cycles", 32'(cyc), 32'(1 + 4 * (dly + 2)));
    chk(exp_q.size() == 0, "R4", "words left", 32'(exp_q.size()), 0);
    @(negedge clk);
    chk(fetch_go == 1'b0, "R6", "pulse width", 32'(fetch_go), 0);
  endtask

  task automatic ignore_instr(input logic [15:0] ins);
    dec_valid = 1'b1;
    instr = ins;
    @(negedge clk);
    dec_valid = 1'b0;
    instr = '0;
    for (int k = 0; k < 4; k++) begin
      chk(!busy && !mem_read && !rf_we, "R2", "ignored instruction activity",
          32'({busy, mem_read, rf_we}), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) rf[k] = '0;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(busy == 1'b0, "R7", "busy in reset", 32'(busy), 0);
    chk(mem_read == 1'b0, "R7", "mem_read in reset", 32'(mem_read), 0);
    chk(rf_we == 1'b0, "R7", "rf_we in reset", 32'(rf_we), 0);
    chk(fetch_go == 1'b0, "R7", "fetch_go in reset", 32'(fetch_go), 0);
    rst = 1'b0;
    @(negedge clk);

    issue(3'd1, 16'h0040, 6'h05, 0, 1'b0);   // R3 positive offset
    issue(3'd2, 16'h1230, 6'h3E, 2, 1'b0);   // R3 base inside R0..R3, negative offset
    issue(3'd0, 16'hFFFC, 6'h00, 1, 1'b0);   // R3 wrap-around
    issue(3'd6, 16'h0800, 6'h1F, 4, 1'b1);   // R2 decode pulse while busy

    ignore_instr(16'h9000);                  // R2 wrong opcode
    ignore_instr(16'h8200);                  // R2 nonzero bits [11:9]

    // R7: reset in mid-sequence
    preload(3'd4, 16'h2000);
    mem_delay = 3;
    dec_valid = 1'b1;
    instr = {4'b1000, 3'b000, 3'd4, 6'h01};
    @(negedge clk);
    dec_valid = 1'b0;
    instr = '0;
    repeat (2) @(negedge clk);
    chk(mem_read == 1'b1, "R5", "request open before reset", 32'(mem_read), 1);
    rst = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_read && !rf_we && !fetch_go, "R7", "idle after mid reset",
        32'({busy, mem_read, rf_we, fetch_go}), 0);
    rst = 1'b0;
    exp_q.delete();
    @(negedge clk);

    issue(3'd3, 16'h7FF0, 6'h20, 3, 1'b0);   // R1 restart after reset, large negative offset

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule